// File: doc/BRIEF.md
# Turbo-Mode ADC Read Controller

This block is the host side of a 16-bit successive-approximation converter used in its 3-wire turbo arrangement, with the converter's serial input tied high. A rising edge on the convert line starts a conversion. The controller reads back the result of the previous conversion while the new one runs. It raises the convert line and holds it high for a first quiet interval. It then lowers the line, which puts the most significant bit on the data line, and generates a burst of serial clocks that shift out the rest of the word.

Each captured word is presented with a one-cycle valid strobe. The first word after reset carries a stale flag, because no earlier conversion exists to supply it. Frames start on a start pulse, or back to back while the free-run input is held high. A request that arrives too early is held back until the second quiet interval, measured from the last serial clock falling edge, has elapsed. The serial clock idles low and comes from the system clock through an even divider.

Top module: `adc_turbo_reader`

## Requirements
- R1: While reset is held, and after it is released until a frame starts, `cnv_o`, `sclk_o` and `word_valid_o` are low and `word_o` is zero.
- R2: `cnv_o` rises only while `free_run_i` is high or a start request (a one-cycle `start_i` pulse) is outstanding. With neither present it stays low.
- R3: In each frame `cnv_o` stays high for exactly QUIET1_CYC clock cycles and then falls.
- R4: Starting at the clock edge where `cnv_o` falls, `sclk_o` makes DATA_BITS periods. Each period is low for SCLK_DIV/2 cycles and then high for SCLK_DIV/2 cycles, and the clock returns low after the last period.
- R5: Data is MSB first. Bit DATA_BITS-1 of `word_o` is the `sdo_i` level seen at the clock edge that produces the first falling edge of `sclk_o`. Each following falling edge supplies the next lower bit, so the last falling edge supplies bit 0.
- R6: `word_valid_o` is high for exactly one cycle per frame. It rises on the clock edge that produces the last falling edge of `sclk_o`, and `word_o` is valid in that same cycle.
- R7: `cnv_o` never rises sooner than QUIET2_CYC cycles after the last falling edge of `sclk_o`. In free-run mode it rises exactly QUIET2_CYC cycles after that edge.
- R8: `word_stale_o` is 1 with the first word after reset and 0 with every later word.
- R9: A start pulse that arrives during a frame or during the second quiet interval is remembered, and it starts exactly one frame as soon as R7 allows.
- R10: `sclk_o` is low in every cycle in which `cnv_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request for one frame |
| free_run_i | input | 1 | While high, frames follow one another at the fastest legal rate |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| word_o | output | DATA_BITS | Last captured word |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |
| word_stale_o | output | 1 | Set with the word read before any earlier conversion existed |

## Verification
The bound checker watches the timing rules on every cycle: the length of each convert pulse, the high time of each serial clock phase, the second quiet interval before a rising convert edge, a silent serial clock while convert is high, and the single-cycle valid strobe that lines up with a falling clock edge. Other behaviour can only be shown by the bench, which runs a converter model that shifts on serial clock falling edges against a behavioural frame timeline. That covers word content and bit order, the stale flag after a reset in the middle of a frame, the absence of frames when nothing requests them, a start pulse held over a busy frame, and back-to-back free-run spacing.

// File: rtl/atr_pkg.sv
// Package atr_pkg
// Shared types for the turbo-mode ADC read controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package atr_pkg;

    // Frame phase seen by the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for a request and for the post-clock quiet time
        PH_CNV  = 2'd1,   // convert line high, first quiet interval running
        PH_READ = 2'd2    // convert line low, serial clock bursting
    } phase_t;

endpackage

// File: rtl/atr_seq.sv
// Module atr_seq
// Frame sequencer: raises the convert line on a request, holds it for the
// first quiet interval, opens the read window, and enforces the second
// quiet interval after the last serial clock fall before the next rise.
// Assumes QUIET1_CYC >= 1 and QUIET2_CYC >= 1; last_fall_i is a one-cycle
// strobe raised only inside the read window.
module atr_seq
    import atr_pkg::*;
#(
    parameter int QUIET1_CYC = 3,
    parameter int QUIET2_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic free_run_i,
    input  logic last_fall_i,
    output logic cnv_o,
    output logic read_o
);
    localparam int Q1W = $clog2(QUIET1_CYC + 1);
    localparam int Q2W = $clog2(QUIET2_CYC + 1);
    localparam logic [Q1W-1:0] Q1_LAST = Q1W'(QUIET1_CYC - 1);
    localparam logic [Q2W-1:0] Q2_FULL = Q2W'(QUIET2_CYC);

    phase_t         ph_q;
    logic [Q1W-1:0] hold_q;
    logic [Q2W-1:0] gap_q;
    logic           pend_q;
    logic           req;
    logic           gap_ok;

    // Request and quiet-window qualifiers.
    always_comb begin
        req    = start_i | pend_q | free_run_i;
        gap_ok = (gap_q == Q2_FULL);
    end

    // Phase progression, quiet counters and the held start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            hold_q <= '0;
            gap_q  <= Q2_FULL;
            pend_q <= 1'b0;
            cnv_o  <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (req && gap_ok) begin
                        ph_q   <= PH_CNV;
                        hold_q <= '0;
                        cnv_o  <= 1'b1;
                        pend_q <= 1'b0;
                    end else begin
                        if (start_i) pend_q <= 1'b1;
                        if (!gap_ok) gap_q <= gap_q + 1'b1;
                    end
                end
                PH_CNV: begin
                    if (start_i) pend_q <= 1'b1;
                    if (hold_q == Q1_LAST) begin
                        cnv_o <= 1'b0;
                        ph_q  <= PH_READ;
                    end else begin
                        hold_q <= hold_q + 1'b1;
                    end
                end
                PH_READ: begin
                    if (start_i) pend_q <= 1'b1;
                    if (last_fall_i) begin
                        ph_q  <= PH_IDLE;
                        gap_q <= Q2W'(1);
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Read window marker for the clock generator and capture unit.
    always_comb read_o = (ph_q == PH_READ);

endmodule

// File: rtl/atr_sclk_gen.sv
// Module atr_sclk_gen
// Serial clock generator: while run_i is high, toggles the serial clock
// every HALF_CYC system cycles, starting from the low level. Flags the
// cycle whose edge will take the clock from high to low.
// Assumes HALF_CYC >= 1; the clock is forced low when run_i is low.
module atr_sclk_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HW-1:0] H_LAST = HW'(HALF_CYC - 1);

    logic [HW-1:0] phase_cnt_q;

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_cnt_q <= '0;
            sclk_o      <= 1'b0;
        end else if (phase_cnt_q == H_LAST) begin
            phase_cnt_q <= '0;
            sclk_o      <= ~sclk_o;
        end else begin
            phase_cnt_q <= phase_cnt_q + 1'b1;
        end
    end

    // Strobe for the edge that lowers the serial clock.
    always_comb fall_o = run_i && sclk_o && (phase_cnt_q == H_LAST);

endmodule

// File: rtl/atr_capture.sv
// Module atr_capture
// Capture unit: shifts the data line in on each serial clock falling edge,
// MSB first. On the last bit it publishes the word with a one-cycle strobe
// and marks the first word after reset as stale.
// Assumes fall_i pulses once per serial clock period inside the read
// window and that clr_i is high outside that window.
module atr_capture #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            fall_i,
    input  logic            sdo_i,
    output logic            last_o,
    output logic [BITS-1:0] word_o,
    output logic            valid_o,
    output logic            stale_o
);
    localparam int BCW = $clog2(BITS);
    localparam logic [BCW-1:0] B_LAST = BCW'(BITS - 1);

    logic [BCW-1:0]  bit_cnt_q;
    logic [BITS-1:0] shreg_q;
    logic            first_q;

    // Final-bit detector.
    always_comb last_o = fall_i && (bit_cnt_q == B_LAST);

    // Bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
        end else if (fall_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            shreg_q   <= {shreg_q[BITS-2:0], sdo_i};
        end
    end

    // Word output, strobe and stale marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            stale_o <= 1'b0;
            first_q <= 1'b1;
        end else begin
            valid_o <= last_o;
            if (last_o) begin
                word_o  <= {shreg_q[BITS-2:0], sdo_i};
                stale_o <= first_q;
                first_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_turbo_reader.sv
// Module adc_turbo_reader
// Host-side controller for a successive-approximation converter in 3-wire
// turbo mode (converter serial input tied high). Each frame raises the
// convert line, waits the first quiet interval, lowers it and bursts
// DATA_BITS serial clocks to read the previous result, then honours the
// second quiet interval before the next frame.
// Assumes SCLK_DIV is even and >= 2, DATA_BITS >= 2, both quiet counts >= 1.
module adc_turbo_reader #(
    parameter int DATA_BITS  = 16,
    parameter int SCLK_DIV   = 4,
    parameter int QUIET1_CYC = 3,
    parameter int QUIET2_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 free_run_i,
    input  logic                 sdo_i,
    output logic                 cnv_o,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] word_o,
    output logic                 word_valid_o,
    output logic                 word_stale_o
);
    localparam int HALF_CYC = SCLK_DIV / 2;

    logic read_win;
    logic fall_stb;
    logic last_stb;

    atr_seq #(
        .QUIET1_CYC (QUIET1_CYC),
        .QUIET2_CYC (QUIET2_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .free_run_i  (free_run_i),
        .last_fall_i (last_stb),
        .cnv_o       (cnv_o),
        .read_o      (read_win)
    );

    atr_sclk_gen #(
        .HALF_CYC (HALF_CYC)
    ) sclk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (read_win),
        .sclk_o (sclk_o),
        .fall_o (fall_stb)
    );

    atr_capture #(
        .BITS (DATA_BITS)
    ) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!read_win),
        .fall_i  (fall_stb),
        .sdo_i   (sdo_i),
        .last_o  (last_stb),
        .word_o  (word_o),
        .valid_o (word_valid_o),
        .stale_o (word_stale_o)
    );

endmodule

// File: rtl/adc_turbo_reader_chk.sv
// Module adc_turbo_reader_chk
// Timing checker bound to adc_turbo_reader. Measures convert pulse width,
// serial clock high time and the gap after the last falling edge with
// its own counters, and checks strobe alignment.
// Assumes the counters never exceed 16 bits between resets of their runs.
module adc_turbo_reader_chk #(
    parameter int SCLK_DIV   = 4,
    parameter int QUIET1_CYC = 3,
    parameter int QUIET2_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic sclk,
    input logic valid
);
    localparam int HALF_CYC = SCLK_DIV / 2;

    logic [15:0] cnv_hi_cnt;
    logic [15:0] sclk_hi_cnt;
    logic [15:0] gap_cnt;
    logic        sclk_prev;

    // Independent run-length and gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_hi_cnt  <= '0;
            sclk_hi_cnt <= '0;
            gap_cnt     <= 16'(QUIET2_CYC);
            sclk_prev   <= 1'b0;
        end else begin
            cnv_hi_cnt  <= cnv  ? cnv_hi_cnt + 16'd1  : 16'd0;
            sclk_hi_cnt <= sclk ? sclk_hi_cnt + 16'd1 : 16'd0;
            sclk_prev   <= sclk;
            if (sclk_prev && !sclk)
                gap_cnt <= 16'd1;
            else if (gap_cnt < 16'(QUIET2_CYC))
                gap_cnt <= gap_cnt + 16'd1;
        end
    end

    // R3: convert pulse is exactly the first quiet interval long.
    p_cnv_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> (cnv_hi_cnt == 16'(QUIET1_CYC)));

    // R4: every serial clock high phase lasts half the divider.
    p_sclk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (sclk_hi_cnt == 16'(HALF_CYC)));

    // R7: second quiet interval respected before a new conversion.
    p_quiet_after_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> (gap_cnt >= 16'(QUIET2_CYC)));

    // R10: no serial clock while the convert line is high.
    p_sclk_quiet_cnv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !sclk);

    // R6: strobe lasts a single cycle.
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: strobe coincides with a falling serial clock.
    p_valid_at_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $fell(sclk));

endmodule

bind adc_turbo_reader adc_turbo_reader_chk #(
    .SCLK_DIV   (SCLK_DIV),
    .QUIET1_CYC (QUIET1_CYC),
    .QUIET2_CYC (QUIET2_CYC)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cnv   (cnv_o),
    .sclk  (sclk_o),
    .valid (word_valid_o)
);

// File: tb/adc_turbo_reader_tb_top.sv
// Bench for adc_turbo_reader: a converter model plus a behavioural frame
// timeline compared against the outputs on every clock.
module adc_turbo_reader_tb_top;
    localparam int DB   = 16;
    localparam int DIV  = 4;
    localparam int Q1   = 3;
    localparam int Q2   = 2;
    localparam int HALF = DIV / 2;
    localparam int RD   = DB * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic free_run = 1'b0;
    logic sdo;
    logic cnv, sclk, valid, stale;
    logic [DB-1:0] word;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    adc_turbo_reader #(
        .DATA_BITS (DB), .SCLK_DIV (DIV), .QUIET1_CYC (Q1), .QUIET2_CYC (Q2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start), .free_run_i (free_run),
        .sdo_i (sdo), .cnv_o (cnv), .sclk_o (sclk), .word_o (word),
        .word_valid_o (valid), .word_stale_o (stale)
    );

    function automatic logic [DB-1:0] pat(input int k);
        case (k)
            0: pat = 16'h8001;
            1: pat = 16'hFFFF;
            2: pat = 16'h0000;
            3: pat = 16'h7FFE;
            4: pat = 16'h5555;
            default: pat = 16'((k * 40503) ^ 32'h0000A5C3);
        endcase
    endfunction

    // Converter model: loads the previous result on convert rise, shifts on SCLK fall.
    logic [DB-1:0] adc_sh = '0;
    logic [DB-1:0] adc_held = '0;
    int adc_k = 0;
    always @(posedge cnv or negedge sclk) begin
        if (cnv) begin
            adc_sh   <= adc_held;
            adc_held <= pat(adc_k);
            adc_k    = adc_k + 1;
        end else begin
            adc_sh <= {adc_sh[DB-2:0], 1'b0};
        end
    end
    assign sdo = adc_sh[DB-1];

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", what, act, exp, cyc);
        end
    endtask

    // Behavioural frame timeline.
    int ph = 0, tk = 0, gap = Q2, frames = 0, conv_total = 0, m_rises = 0;
    bit pend = 0, armed = 0, req;
    logic e_cnv = 0, e_sclk = 0, e_valid = 0, e_stale = 0;
    logic [DB-1:0] e_word = '0, cur_word = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = 0; tk = 0; gap = Q2; pend = 0; frames = 0;
            e_cnv = 0; e_sclk = 0; e_valid = 0; e_word = '0; armed = 1;
        end else begin
            req = start || pend || free_run;
            e_valid = 0;
            if (ph == 0) begin
                if (gap < Q2) gap++;
                if (req && gap >= Q2) begin
                    ph = 1; tk = 0; e_cnv = 1; pend = 0; m_rises++;
                    cur_word = (conv_total == 0) ? '0 : pat(conv_total - 1);
                    conv_total++;
                end else if (start) pend = 1;
            end else if (ph == 1) begin
                if (start) pend = 1;
                tk++;
                if (tk == Q1) begin e_cnv = 0; ph = 2; tk = 0; end
            end else begin
                if (start) pend = 1;
                tk++;
                if (tk == RD) begin
                    e_sclk = 0; e_valid = 1; e_word = cur_word;
                    e_stale = (frames == 0); frames++; ph = 0; gap = 0;
                end else begin
                    e_sclk = ((tk / HALF) % 2) == 1;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    int vcnt = 0, dut_rises = 0;
    logic last_stale = 0;
    always @(posedge cnv) dut_rises++;
    always @(negedge clk) begin
        if (armed) begin
            check(cnv === e_cnv, "R2 R3 R7 R9 cnv", 32'(cnv), 32'(e_cnv));
            check(sclk === e_sclk, "R4 sclk", 32'(sclk), 32'(e_sclk));
            check(valid === e_valid, "R6 valid", 32'(valid), 32'(e_valid));
            check(!(cnv && sclk), "R10 sclk during cnv", 32'(sclk), 32'd0);
            if (e_valid) begin
                check(word === e_word, "R5 word", 32'(word), 32'(e_word));
                check(stale === e_stale, "R8 stale", 32'(stale), 32'(e_stale));
            end
            if (rst_n && valid) begin vcnt++; last_stale = stale; end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected<=20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cnv === 1'b0 && sclk === 1'b0, "R1 reset lines", {30'd0, cnv, sclk}, 32'd0);
        check(valid === 1'b0 && word === '0, "R1 reset word", 32'(word), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (30) @(negedge clk);
        // R2: no request, no conversion
        check(dut_rises == 0, "R2 idle no cnv", dut_rises, 0);
        pulse_start();
        repeat (Q1 + RD + 10) @(negedge clk);
        check(vcnt == 1, "R6 one word per start", vcnt, 1);
        check(last_stale === 1'b1, "R8 first word stale", 32'(last_stale), 32'd1);
        // R9: second start arrives mid-frame
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        repeat (2 * (Q1 + RD + Q2) + 20) @(negedge clk);
        check(vcnt == 3, "R9 held start served once", vcnt, 3);
        check(last_stale === 1'b0, "R8 later word fresh", 32'(last_stale), 32'd0);
        // R7: free-run, back-to-back frames
        @(negedge clk) free_run = 1'b1;
        repeat (5 * (Q1 + RD + Q2)) @(negedge clk);
        free_run = 1'b0;
        repeat (Q1 + RD + Q2 + 10) @(negedge clk);
        check(dut_rises == m_rises, "R7 free-run frame count", dut_rises, m_rises);
        check(vcnt == 3 + m_rises - 3, "R6 words match frames", vcnt, m_rises);
        // R1 and R8: reset in the middle of a frame
        pulse_start();
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(cnv === 1'b0 && sclk === 1'b0 && valid === 1'b0, "R1 mid-frame reset", {29'd0, cnv, sclk, valid}, 32'd0);
        rst_n = 1'b1;
        pulse_start();
        repeat (Q1 + RD + 10) @(negedge clk);
        check(last_stale === 1'b1, "R8 stale after reset", 32'(last_stale), 32'd1);
        pulse_start();
        repeat (Q1 + RD + Q2 + 10) @(negedge clk);
        check(last_stale === 1'b0, "R8 fresh after reset", 32'(last_stale), 32'd0);
        check(dut_rises == m_rises, "R2 total conversions", dut_rises, m_rises);
        summary();
        $finish;
    end
endmodule